// File: doc/BRIEF.md
# Quad-Capable Serial Flash Read Sequencer

This block is a bus master that pulls a run of bytes out of a serial NOR flash. A client gives a start address, a byte count and one of three read kinds, then pulses `start`. The sequencer pulls chip select low and sends an opcode byte and a 24-bit address on the single output line. If the read kind needs it, it then gives eight dummy clocks. After that it receives data, either one bit per serial clock on the flash output line or one nibble per clock on all four IO lines. Each finished byte goes out on a valid/ready stream.

The serial clock runs at half the system clock and idles low (mode 0). The sequencer changes its own outputs on the falling edge of the serial clock, and the flash latches them on the rising edge. The sequencer samples the flash's data at the rising edge. The header and dummy phases always use one line. Only the quad kind switches the data phase to four lanes. When the consumer holds the stream, the serial clock stops rather than dropping a byte.

The states are IDLE, CMD, ADDR, DUMMY, DATA and TAIL, with these transitions:
- IDLE→CMD on an accepted start.
- CMD→ADDR after 8 bits.
- ADDR→DUMMY after 24 bits for the fast and quad kinds, or ADDR→DATA for the plain kind.
- DUMMY→DATA after 8 clocks.
- DATA→TAIL after the last requested byte.
- TAIL→IDLE, which raises chip select.

Top module: `qspi_read_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `busy` is 0, `rd_valid` is 0 and `mosi_oe` is 0.
- R2: `rd_kind` picks the opcode: 00 gives 0x03, 01 gives 0x0B, 10 gives 0x6B and 11 gives 0x03. The opcode goes out first, followed by the 24-bit address, both MSB first on `mosi`, with `mosi_oe` high. `mosi_oe` is never high while `cs_n` is high.
- R3: Kinds 00 and 11 add no dummy clocks. Kinds 01 and 10 add 8 dummy clocks, so the header is 40 rising `sck` edges. The total number of rising edges in a transaction is the header length plus the data clocks.
- R4: In single-line kinds, each data byte takes 8 clocks and is sampled from `io_in[1]`, MSB first.
- R5: In the quad kind, each byte takes 2 clocks and is sampled from `io_in[3:0]`, high nibble first.
- R6: The transaction delivers exactly `byte_count` bytes from consecutive addresses, with the address wrapping at 24 bits. `cs_n` stays low from the first clock until after the last data clock and is high at the end. `sck` is low whenever `cs_n` is high.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady and `sck` does not rise in the data phase. No byte is lost or duplicated.
- R8: A `start` with `byte_count` of 0, or a `start` while `busy` is high, is ignored.
- R9: Every high phase of `sck` lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken in IDLE |
| rd_kind | input | 2 | Read kind select (see R2) |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | High while a transaction is in progress |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Command, address and dummy line (IO0) |
| mosi_oe | output | 1 | Output enable for IO0 |
| io_in | input | 4 | Sampled flash IO lines IO3..IO0 |

## Verification
A behavioural flash model on the serial pins decodes the opcode and address it receives. It then drives data from an address-derived pattern, so every delivered byte shows whether the bit or nibble order and the byte ordering are right. Each of the four `rd_kind` codes is run, which separates the zero-dummy and eight-dummy headers by their rising-edge counts and separates single-lane from quad-lane sampling. Random consumer back-pressure levels, from none to heavy, show whether the clock stalls without losing bytes. Directed cases cover a one-byte read, an address that wraps at the top of the 24-bit space, a zero-length start and a second start during a busy transaction.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_DUMMY,
        S_DATA,
        S_TAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        RD_PLAIN = 2'b00,
        RD_FAST  = 2'b01,
        RD_QUAD  = 2'b10,
        RD_ALT   = 2'b11
    } rd_kind_t;

    function automatic logic [7:0] opcode_of(input logic [1:0] kind);
        case (kind)
            2'b01:   return 8'h0B;
            2'b10:   return 8'h6B;
            default: return 8'h03;
        endcase
    endfunction

    function automatic logic needs_dummy(input logic [1:0] kind);
        return (kind == 2'b01) || (kind == 2'b10);
    endfunction

endpackage

// File: rtl/qspi_hdr_shifter.sv
module qspi_hdr_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/qspi_byte_gather.sv
module qspi_byte_gather (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sample,
    input  logic       quad,
    input  logic [3:0] lanes,
    output logic       done,
    output logic [7:0] byte_nx
);
    logic [7:0] acc_q;
    logic [2:0] cnt_q;
    logic       last;

    assign byte_nx = quad ? {acc_q[3:0], lanes} : {acc_q[6:0], lanes[1]};
    assign last    = quad ? (cnt_q == 3'd1) : (cnt_q == 3'd7);
    assign done    = sample && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (sample) begin
            acc_q <= byte_nx;
            cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
        end
    end
endmodule

// File: rtl/qspi_read_seq.sv
module qspi_read_seq
    import qspi_rd_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 24,
    parameter int CMD_W      = 8,
    parameter int DUMMY_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        rd_kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    output logic              busy,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic [3:0]        io_in
);
    localparam int HDR_W = CMD_W + ADDR_W;
    localparam int BIT_W = $clog2(HDR_W);

    seq_state_t       state, state_nx;
    logic [1:0]       kind_q;
    logic [BIT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] remain;
    logic             sck_q, cs_q, valid_q;
    logic [7:0]       out_q;
    logic             go, in_hdr, hdr_step, last_bit, cap, quad, done, hdr_msb;
    logic [7:0]       byte_nx;

    assign go       = (state == S_IDLE) && start && (byte_count != '0);
    assign in_hdr   = (state == S_CMD) || (state == S_ADDR) || (state == S_DUMMY);
    assign hdr_step = sck_q && in_hdr;
    assign last_bit = (bit_cnt == '0);
    assign cap      = (state == S_DATA) && !sck_q && (!valid_q || rd_ready);
    assign quad     = (kind_q == RD_QUAD);

    qspi_hdr_shifter #(.W(HDR_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val ({opcode_of(rd_kind), start_addr}),
        .shift    (hdr_step),
        .msb      (hdr_msb)
    );

    qspi_byte_gather u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (go),
        .sample  (cap),
        .quad    (quad),
        .lanes   (io_in),
        .done    (done),
        .byte_nx (byte_nx)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (go) state_nx = S_CMD;
            S_CMD:   if (hdr_step && last_bit) state_nx = S_ADDR;
            S_ADDR:  if (hdr_step && last_bit)
                         state_nx = needs_dummy(kind_q) ? S_DUMMY : S_DATA;
            S_DUMMY: if (hdr_step && last_bit) state_nx = S_DATA;
            S_DATA:  if (sck_q && remain == '0) state_nx = S_TAIL;
            S_TAIL:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            remain  <= '0;
            kind_q  <= RD_PLAIN;
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            cs_q <= (state_nx == S_IDLE);
            unique case (state)
                S_IDLE: begin
                    sck_q <= 1'b0;
                    if (go) begin
                        kind_q  <= rd_kind;
                        remain  <= byte_count;
                        bit_cnt <= BIT_W'(CMD_W - 1);
                    end
                end
                S_CMD, S_ADDR, S_DUMMY: begin
                    sck_q <= !sck_q;
                    if (hdr_step) begin
                        if (last_bit)
                            bit_cnt <= (state == S_CMD) ? BIT_W'(ADDR_W - 1)
                                                        : BIT_W'(DUMMY_CLKS - 1);
                        else
                            bit_cnt <= bit_cnt - 1'b1;
                    end
                end
                S_DATA: begin
                    if (cap)        sck_q <= 1'b1;
                    else if (sck_q) sck_q <= 1'b0;
                    if (cap && done) remain <= remain - 1'b1;
                end
                S_TAIL:  sck_q <= 1'b0;
                default: sck_q <= 1'b0;
            endcase
            if (cap && done) begin
                valid_q <= 1'b1;
                out_q   <= byte_nx;
            end else if (rd_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign busy     = (state != S_IDLE);
    assign sck      = sck_q;
    assign cs_n     = cs_q;
    assign rd_valid = valid_q;
    assign rd_data  = out_q;
    assign mosi_oe  = in_hdr;
    assign mosi     = (state == S_CMD || state == S_ADDR) ? hdr_msb : 1'b0;

    a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    a_r2_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe |-> !cs_n);
    a_r9_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck);
    a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    a_r7_stall_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !sck && rd_valid && !rd_ready) |=> !sck);
    a_r8_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && byte_count == '0) |=> (!busy && cs_n));
    a_r6_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != S_TAIL) |=> !cs_n);
endmodule

// File: tb/qspi_read_seq_tb.sv
module qspi_read_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  rd_kind;
    logic [23:0] start_addr;
    logic [15:0] byte_count;
    logic        busy, rd_valid, cs_n, sck, mosi, mosi_oe;
    logic        rd_ready;
    logic [7:0]  rd_data;
    logic [3:0]  io_in;

    always #5 clk = ~clk;

    qspi_read_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_kind(rd_kind),
        .start_addr(start_addr), .byte_count(byte_count), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe), .io_in(io_in)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    function automatic logic [7:0] mem_of(input logic [23:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] op_of(input logic [1:0] k);
        return (k == 2'b01) ? 8'h0B : (k == 2'b10) ? 8'h6B : 8'h03;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // flash model
    int          rises = 0;
    int          oe_bad = 0;
    logic [31:0] hdr_rx = '0;
    int          fi, hl;
    logic [7:0]  fb;

    always @(negedge cs_n) begin
        rises  = 0;
        hdr_rx = '0;
        oe_bad = 0;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            if (rises < 32) begin
                hdr_rx = {hdr_rx[30:0], mosi};
                if (!mosi_oe) oe_bad++;
            end
            rises++;
        end
    end

    always @(negedge sck) begin
        if (!cs_n && rises >= 32) begin
            hl = (hdr_rx[31:24] == 8'h03) ? 32 : 40;
            if (rises >= hl) begin
                fi = rises - hl;
                if (hdr_rx[31:24] == 8'h6B) begin
                    fb = mem_of(hdr_rx[23:0] + 24'(fi / 2));
                    io_in <= (fi % 2 == 0) ? fb[7:4] : fb[3:0];
                end else begin
                    fb = mem_of(hdr_rx[23:0] + 24'(fi / 8));
                    io_in <= {2'b00, fb[7 - (fi % 8)], 1'b0};
                end
            end
        end
    end

    // consumer
    int         bp = 0;
    int         nrx = 0;
    logic [23:0] exp_addr = '0;
    bit         cur_quad = 0;

    always @(negedge clk) begin
        rd_ready = (($urandom % 100) >= bp);
        if (rd_valid && rd_ready) begin
            check(rd_data == mem_of(exp_addr + 24'(nrx)),
                  cur_quad ? "R5" : "R4", "data byte",
                  rd_data, mem_of(exp_addr + 24'(nrx)));
            nrx++;
        end
    end

    task automatic run_xfer(input logic [1:0] k, input logic [23:0] a,
                            input int cnt, input int bpct, input bit restart);
        int hlen;
        exp_addr = a;
        nrx      = 0;
        bp       = bpct;
        cur_quad = (k == 2'b10);
        @(negedge clk);
        rd_kind = k; start_addr = a; byte_count = 16'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R6", "busy after start", busy, 1);
        if (restart) begin
            repeat (6) @(negedge clk);
            start = 1'b1; start_addr = a ^ 24'h555555; rd_kind = 2'b10;
            byte_count = 16'd9;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy || rd_valid) @(negedge clk);
        hlen = (k == 2'b01 || k == 2'b10) ? 40 : 32;
        check(nrx == cnt, restart ? "R8" : "R6", "byte count", nrx, cnt);
        check(hdr_rx[31:24] == op_of(k), "R2", "opcode", hdr_rx[31:24], op_of(k));
        check(hdr_rx[23:0] == a, "R2", "address", hdr_rx[23:0], a);
        check(oe_bad == 0, "R2", "oe during header", oe_bad, 0);
        check(rises == hlen + cnt * (cur_quad ? 2 : 8), "R3", "sck rises",
              rises, hlen + cnt * (cur_quad ? 2 : 8));
        check(cs_n == 1'b1 && sck == 1'b0, "R6", "idle pins", {cs_n, sck}, 2'b10);
        bp = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; rd_kind = 2'b00; start_addr = '0;
        byte_count = '0; io_in = '0;
        repeat (3) @(negedge clk);
        check(cs_n == 1 && sck == 0 && busy == 0 && rd_valid == 0 && mosi_oe == 0,
              "R1", "reset pins", {cs_n, sck, busy, rd_valid, mosi_oe}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1 && busy == 0, "R1", "after reset release", {cs_n, busy}, 2'b10);

        run_xfer(2'b00, 24'h012345, 1, 0, 0);
        run_xfer(2'b01, 24'h00A0F0, 3, 0, 0);
        run_xfer(2'b10, 24'h3C0001, 1, 0, 0);
        run_xfer(2'b10, 24'h000100, 5, 85, 0);
        run_xfer(2'b01, 24'hFFFFFE, 4, 50, 0);
        run_xfer(2'b11, 24'h777777, 2, 0, 0);

        // zero-length start must be ignored
        @(negedge clk);
        start = 1'b1; byte_count = '0; rd_kind = 2'b01;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (busy || !cs_n) begin
                check(0, "R8", "zero count started", {busy, cs_n}, 2'b01);
                break;
            end
            @(negedge clk);
        end
        check(busy == 0 && cs_n == 1 && rd_valid == 0, "R8", "zero count idle",
              {busy, cs_n, rd_valid}, 3'b010);

        run_xfer(2'b00, 24'h400040, 3, 30, 1);

        for (int t = 0; t < 14; t++) begin
            run_xfer(2'($urandom % 4), 24'($urandom), 1 + ($urandom % 6),
                     $urandom % 75, 0);
        end
        finish_run();
    end
endmodule